// File: doc/BRIEF.md
# Timeslot-Gated PRBS Bit Error Counter

This block watches one serial TDM input stream and counts bit errors against a pseudo-random reference of length 2^15-1. A frame is cut into a fixed number of timeslots of equal length. A small enable memory holds one bit per timeslot, and only the timeslots whose bit is set take part in the test. The checker ignores the bits of every other slot. While those bits go by, the reference is held still. So a test pattern spread over scattered slots is seen as one unbroken sequence.

After reset the checker loads the first fifteen monitored bits as its starting state, and no errors are counted during that time. From then on it runs its own generator and compares each monitored bit with the bit it predicts. Each differing bit adds one to a 16-bit counter, which stops at its maximum value. A host port reads the counter or any enable location, sets or clears enable bits, and clears the counter by writing to it. The block runs on the bit clock. A frame pulse marks the first bit of timeslot 0.

Top module: `tsber_mon`

## Requirements
- R1: After reset the error count reads 0 and every enable location reads 0.
- R2: With host_sel = 0, a write stores host_wbit into the enable location of the timeslot given by host_addr. A read returns that bit in bit 0, and bits 15..1 read as zero.
- R3: A bit sampled with frame_sync high is bit 0 of timeslot 0. Timeslot k covers frame bits k*8 to k*8+7 of a 256-bit frame. Bits before the first frame_sync are never monitored.
- R4: The first 15 monitored bits after reset load the reference state, and no error is counted for them. A clean sequence from any nonzero starting point then gives a count of 0.
- R5: After loading, each monitored bit is compared with the predicted bit b[n] = b[n-15] XOR b[n-14], taken over the monitored bits only. Each mismatch adds exactly 1 to the count on the same clock edge.
- R6: After loading, the reference advances from its own predicted bit and not from the received bit. A single flipped bit therefore adds exactly 1.
- R7: Bits in disabled timeslots count no error and leave the reference unchanged, whatever their value. The sequence resumes in the next enabled slot no matter how large the gap.
- R8: The count saturates at 16'hFFFF and stays there while further errors arrive.
- R9: A write with host_sel = 1 sets the count to 0. If an error arrives on the same edge, the clear wins.
- R10: Any set of timeslots may be enabled at once, and they are monitored together as one sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | High with the first bit of timeslot 0 |
| rx_bit | input | 1 | Serial stream data |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_sel | input | 1 | 0 = enable memory, 1 = error count |
| host_addr | input | 5 | Timeslot index for enable access |
| host_wbit | input | 1 | Enable value to store |
| host_rdata | output | 16 | Read data for the selected target |

## Verification
On every cycle, the assertions check these behaviours: errors appear only in monitored bits that follow the load phase; the reference state holds still outside monitored bits; the count moves by at most one, never wraps, and drops to zero after a clear; and an enable read has no stray high bits. Other behaviours can only be shown by the bench's scenarios, each run against its own model of the transmitted sequence: that the right slots are the ones monitored, that a sequence spread across gaps full of junk lines up again, that data before framing is ignored, and that the count matches the number of injected flips exactly.

// File: rtl/tsber_pkg.sv
package tsber_pkg;
  localparam int PRBS_W = 15;
  localparam int TAP_HI = 14;
  localparam int TAP_LO = 13;
  localparam int FILL_W = $clog2(PRBS_W + 1);

  typedef logic [PRBS_W-1:0] prbs_t;

  typedef enum logic {
    HSEL_ENABLE = 1'b0,
    HSEL_COUNT  = 1'b1
  } hsel_e;

  // predicted next bit of the x^15 + x^14 + 1 sequence
  function automatic logic prbs_feedback(input prbs_t s);
    return s[TAP_HI] ^ s[TAP_LO];
  endfunction

  // shift a new bit into the low end of the history
  function automatic prbs_t prbs_advance(input prbs_t s, input logic b);
    return {s[PRBS_W-2:0], b};
  endfunction
endpackage

// File: rtl/tsber_slot_timer.sv
module tsber_slot_timer #(
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8,
  parameter int SLOT_AW   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_sync,
  output logic               framed,
  output logic [SLOT_AW-1:0] slot_idx
);
  localparam int FRAME_BITS = SLOTS * SLOT_BITS;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] SLOT_LEN = POS_W'(SLOT_BITS);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] cur_pos;
  logic             framed_q;

  assign cur_pos  = frame_sync ? '0 : pos_q;
  assign framed   = framed_q | frame_sync;
  assign slot_idx = SLOT_AW'(cur_pos / SLOT_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      framed_q <= 1'b0;
    end else begin
      pos_q    <= (cur_pos == LAST_POS) ? '0 : cur_pos + 1'b1;
      framed_q <= framed;
    end
  end
endmodule

// File: rtl/tsber_en_mem.sv
module tsber_en_mem #(
  parameter int SLOTS   = 32,
  parameter int SLOT_AW = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SLOT_AW-1:0] wr_addr,
  input  logic               wr_bit,
  input  logic [SLOT_AW-1:0] rd_addr,
  output logic               rd_bit,
  input  logic [SLOT_AW-1:0] look_addr,
  output logic               look_bit
);
  logic [SLOTS-1:0] en_vec;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bit_q <= 1'b0;
      else if (wr_en && (wr_addr == SLOT_AW'(g)))
        bit_q <= wr_bit;
    end
    assign en_vec[g] = bit_q;
  end

  assign rd_bit   = en_vec[rd_addr];
  assign look_bit = en_vec[look_addr];
endmodule

// File: rtl/tsber_prbs_chk.sv
module tsber_prbs_chk
  import tsber_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bit_en,
  input  logic  rx_bit,
  output logic  seeded,
  output logic  err_bit,
  output prbs_t state_q
);
  logic [FILL_W-1:0] fill_q;
  logic              exp_bit;

  assign seeded  = (fill_q == FILL_W'(PRBS_W));
  assign exp_bit = prbs_feedback(state_q);
  assign err_bit = bit_en & seeded & (rx_bit ^ exp_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      fill_q  <= '0;
    end else if (bit_en) begin
      if (seeded) begin
        state_q <= prbs_advance(state_q, exp_bit);
      end else begin
        state_q <= prbs_advance(state_q, rx_bit);
        fill_q  <= fill_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsber_err_cnt.sv
module tsber_err_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hit,
  output logic [CNT_W-1:0] count_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] v, input logic inc);
    return (inc && (v != CNT_MAX)) ? v + 1'b1 : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count_q <= '0;
    else if (clr)
      count_q <= '0;
    else
      count_q <= sat_step(count_q, hit);
  end
endmodule

// File: rtl/tsber_mon.sv
module tsber_mon
  import tsber_pkg::*;
#(
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8,
  parameter int CNT_W     = 16,
  parameter int SLOT_AW   = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_sync,
  input  logic               rx_bit,
  input  logic               host_wr,
  input  logic               host_sel,
  input  logic [SLOT_AW-1:0] host_addr,
  input  logic               host_wbit,
  output logic [CNT_W-1:0]   host_rdata
);
  logic               framed;
  logic [SLOT_AW-1:0] cur_slot;
  logic               slot_on;
  logic               bit_en;
  logic               seeded;
  logic               err_bit;
  prbs_t              prbs_q;
  logic               cnt_clr;
  logic               en_wr;
  logic               en_rd;
  logic [CNT_W-1:0]   count_q;
  hsel_e              sel;

  assign sel     = hsel_e'(host_sel);
  assign cnt_clr = host_wr & (sel == HSEL_COUNT);
  assign en_wr   = host_wr & (sel == HSEL_ENABLE);
  assign bit_en  = framed & slot_on;

  tsber_slot_timer #(
    .SLOTS    (SLOTS),
    .SLOT_BITS(SLOT_BITS),
    .SLOT_AW  (SLOT_AW)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_sync(frame_sync),
    .framed    (framed),
    .slot_idx  (cur_slot)
  );

  tsber_en_mem #(
    .SLOTS  (SLOTS),
    .SLOT_AW(SLOT_AW)
  ) u_enmem (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (en_wr),
    .wr_addr  (host_addr),
    .wr_bit   (host_wbit),
    .rd_addr  (host_addr),
    .rd_bit   (en_rd),
    .look_addr(cur_slot),
    .look_bit (slot_on)
  );

  tsber_prbs_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_en (bit_en),
    .rx_bit (rx_bit),
    .seeded (seeded),
    .err_bit(err_bit),
    .state_q(prbs_q)
  );

  tsber_err_cnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cnt_clr),
    .hit    (err_bit),
    .count_q(count_q)
  );

  assign host_rdata = (sel == HSEL_COUNT) ? count_q : {{(CNT_W-1){1'b0}}, en_rd};
endmodule

// File: rtl/tsber_mon_chk.sv
module tsber_mon_chk
  import tsber_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             framed,
  input logic             bit_en,
  input logic             seeded,
  input logic             err_bit,
  input prbs_t            prbs_q,
  input logic             cnt_clr,
  input logic [CNT_W-1:0] count_q,
  input logic             host_sel,
  input logic [CNT_W-1:0] host_rdata
);
  localparam logic [CNT_W-1:0] FULL = '1;

  AST_BIT_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |-> framed);  // R3
  AST_NO_ERR_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
    !seeded |-> !err_bit);  // R4
  AST_ERR_IN_SLOT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    err_bit |-> bit_en);  // R7
  AST_STATE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(prbs_q));  // R7
  AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1));  // R5
  AST_ERR_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_bit && !cnt_clr && (count_q != FULL)) |=> count_q == $past(count_q) + 1'b1);  // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((count_q == FULL) && !cnt_clr) |=> count_q == FULL);  // R8
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> count_q == '0);  // R9
  AST_EN_READ_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    !host_sel |-> (host_rdata >> 1) == '0);  // R2
endmodule

bind tsber_mon tsber_mon_chk #(.CNT_W(CNT_W)) i_tsber_mon_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .framed    (framed),
  .bit_en    (bit_en),
  .seeded    (seeded),
  .err_bit   (err_bit),
  .prbs_q    (prbs_q),
  .cnt_clr   (cnt_clr),
  .count_q   (count_q),
  .host_sel  (host_sel),
  .host_rdata(host_rdata)
);

// File: tb/test_tsber_mon.sv
module test_tsber_mon;
  localparam int SLOT_BITS = 8;
  localparam int FRAME     = 256;
  localparam int CMAX      = 65535;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_sync = 1'b0;
  logic        rx_bit = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_sel = 1'b0;
  logic [4:0]  host_addr = '0;
  logic        host_wbit = 1'b0;
  logic [15:0] host_rdata;

  always #2 clk = ~clk;

  tsber_mon i_tsber_mon (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .rx_bit(rx_bit),
    .host_wr(host_wr), .host_sel(host_sel), .host_addr(host_addr),
    .host_wbit(host_wbit), .host_rdata(host_rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // stream model
  logic [14:0] tx = 15'h1ACE;
  logic [31:0] en_m = '0;
  int idx = 0, pos = 0, pre_idle = 0;
  int flip_per = 0, flip_ph = 0;
  int exp_cnt = 0;
  bit pend = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      frame_sync = 1'b0;
      rx_bit     = 1'b0;
    end else if (pre_idle > 0) begin
      pre_idle   = pre_idle - 1;
      frame_sync = 1'b0;
      rx_bit     = (pre_idle % 3) == 1;
    end else begin
      frame_sync = (pos == 0);
      if (en_m[pos / SLOT_BITS]) begin
        logic nb, fl;
        nb = tx[14] ^ tx[13];
        tx = {tx[13:0], nb};
        fl = (flip_per != 0) && (idx >= 15) && ((idx % flip_per) == flip_ph);
        rx_bit = nb ^ fl;
        if (fl) pend = 1;
        idx++;
      end else begin
        rx_bit = ((pos % 5) == 2) || ((pos % 7) == 0);
      end
      pos = (pos + 1) % FRAME;
    end
  end

  always @(posedge clk) begin
    if (host_wr && host_sel) exp_cnt = 0;
    else if (pend && exp_cnt < CMAX) exp_cnt++;
    pend = 0;
    if (host_wr && !host_sel) en_m[host_addr] = host_wbit;
  end

  task automatic compare(input logic [15:0] act, input logic [15:0] expv, input string tag);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic do_reset(input int idle);
    @(negedge clk);
    rst_n = 1'b0; host_wr = 1'b0; host_sel = 1'b0;
    repeat (2) @(negedge clk);
    tx = 15'h1ACE; idx = 0; pos = 0; en_m = '0;
    flip_per = 0; flip_ph = 0; exp_cnt = 0; pend = 0; pre_idle = idle;
    @(posedge clk); #1 rst_n = 1'b1;
  endtask

  task automatic host_write(input logic sel, input int addr, input logic b);
    @(negedge clk);
    host_sel = sel; host_addr = 5'(addr); host_wbit = b; host_wr = 1'b1;
    @(posedge clk); #1 host_wr = 1'b0;
  endtask

  task automatic check_en(input int addr, input logic b, input string tag);
    host_sel = 1'b0; host_addr = 5'(addr);
    @(posedge clk); #1;
    compare(host_rdata, {15'b0, b}, tag);
  endtask

  task automatic check_cnt(input string tag);
    host_sel = 1'b1;
    @(posedge clk); #1;
    compare(host_rdata, 16'(exp_cnt), tag);
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic t_reset;
    do_reset(60);
    check_cnt("R1 count after reset");
    check_en(0, 1'b0, "R1 slot 0 enable");
    check_en(17, 1'b0, "R1 slot 17 enable");
    check_en(31, 1'b0, "R1 slot 31 enable");
  endtask

  task automatic t_enable_mem;
    do_reset(60);
    host_write(1'b0, 3, 1'b1);
    check_en(3, 1'b1, "R2 slot 3 set");
    check_en(4, 1'b0, "R2 slot 4 untouched");
    host_write(1'b0, 5, 1'b0);
    check_en(5, 1'b0, "R2 slot 5 cleared");
    host_write(1'b0, 3, 1'b0);
    check_en(3, 1'b0, "R2 slot 3 cleared");
  endtask

  task automatic t_single_slot;
    do_reset(40);
    host_write(1'b0, 2, 1'b1);
    wait_cycles(20 * FRAME);
    check_cnt("R4 R5 clean stream in slot 2");
    flip_per = 37; flip_ph = 5;
    wait_cycles(20 * FRAME);
    check_cnt("R6 single flips in slot 2");
    compare(16'(exp_cnt == 0), 16'd0, "R6 flips were injected");
  endtask

  task automatic t_gaps;
    do_reset(40);
    host_write(1'b0, 0, 1'b1);
    host_write(1'b0, 7, 1'b1);
    host_write(1'b0, 20, 1'b1);
    host_write(1'b0, 31, 1'b1);
    wait_cycles(6 * FRAME);
    check_cnt("R7 R10 clean across gaps");
    flip_per = 11; flip_ph = 3;
    wait_cycles(24 * FRAME);
    check_cnt("R7 R10 R3 flips across gaps");
  endtask

  task automatic t_preframe;
    do_reset(150);
    host_write(1'b0, 1, 1'b1);
    host_write(1'b0, 30, 1'b1);
    wait_cycles(150 + 10 * FRAME);
    check_cnt("R3 R4 junk before first frame ignored");
  endtask

  task automatic t_clear_and_sat;
    do_reset(100);
    for (int s = 0; s < 32; s++) host_write(1'b0, s, 1'b1);
    flip_per = 1; flip_ph = 0;
    wait_cycles(300);
    check_cnt("R5 every bit in error");
    host_write(1'b1, 0, 1'b0);
    compare(host_rdata, 16'h0000, "R9 clear wins over error");
    wait_cycles(100);
    check_cnt("R9 counting resumes after clear");
    wait_cycles(66000);
    compare(host_rdata, 16'hFFFF, "R8 saturated");
    check_cnt("R8 saturated model");
    wait_cycles(500);
    compare(host_rdata, 16'hFFFF, "R8 stays saturated");
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_enable_mem();
    t_single_slot();
    t_gaps();
    t_preframe();
    t_clear_and_sat();
    summary();
    $finish;
  end
endmodule